// File: doc/BRIEF.md
# Dual-Bridge Overcurrent and Thermal Protection Sequencer

This block supervises two full power bridges. For each bridge it receives a comparator flag that goes high when the high-side current crosses its limit. It also receives an 8-bit die temperature code in degrees Celsius. From these it drives a fault indication per bridge and the enable that actually reaches each bridge.

When a bridge sees an overcurrent, its fault output rises at once. The bridge keeps running for a programmable number of cycles, then switches off for a second programmable interval, and then comes back on by itself. If the fault persists, the cycle repeats, which gives a hiccup-style current limit.

An over-temperature condition forces both bridges off and raises both fault outputs. It clears only once the temperature has dropped well below the trip point. When the two bridges are wired in parallel, a configuration input ties their enables together, so that an overcurrent on either one stops both.

Top module: `bridge_guard_top`

## Requirements
- R1: While `rst` is high, `bridge_en` and `fault` are both 0. Both bits of `bridge_en` read 1 after the first clock edge with `rst` low.
- R2: Each `oc_raw` bit passes through a two-flip-flop synchronizer. The matching `fault` bit is still 0 two rising edges after the flag rises and is 1 after the third edge.
- R3: Bit i of `fault` reflects only bridge i's overcurrent flag; bit 0 is bridge 0 and bit 1 is bridge 1. With `link_en` low, an overcurrent on one bridge leaves the other bridge's enable at 1.
- R4: After an overcurrent flag rises, that bridge's enable stays 1 for DELAY_CYCLES+3 rising edges and is 0 after edge DELAY_CYCLES+4.
- R5: Once off, the bridge stays off for DISABLE_CYCLES. If the flag has cleared, its enable is 0 after edge DELAY_CYCLES+DISABLE_CYCLES+3 and 1 after edge DELAY_CYCLES+DISABLE_CYCLES+4, counted from the flag's rise.
- R6: If the flag is still high when the off time ends, the bridge runs for one cycle and starts a fresh delay. Its enable is 1 after edge 2*DELAY_CYCLES+DISABLE_CYCLES+4 and 0 after edge 2*DELAY_CYCLES+DISABLE_CYCLES+5.
- R7: A temperature code at or above TRIP_TEMP (default 165) puts the block into shutdown. Two edges later both enables read 0 and both fault bits read 1, whatever state each bridge is in.
- R8: Shutdown stays active while the code is above RELEASE_TEMP (default 150). It ends when the code is at or below RELEASE_TEMP, and two edges later the enables of running bridges read 1 again.
- R9: With `link_en` high, an overcurrent on either bridge drives both enables to 0 on the schedule of R4, while `fault` still marks only the bridge that saw the overcurrent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_raw | input | 2 | Asynchronous per-bridge overcurrent comparator flags |
| temp_code | input | 8 | Die temperature, unsigned degrees Celsius |
| link_en | input | 1 | 1 = paralleled bridges, enables tied together |
| fault | output | 2 | Per-bridge fault indication (overcurrent or thermal) |
| bridge_en | output | 2 | Effective enable for each bridge |

## Verification
The results arrive at different latencies:

- A flag edge reaches `fault` after three rising edges: two synchronizer stages and the output register.
- The sequencer adds one more edge before `bridge_en` moves, so the off and on transitions land at DELAY_CYCLES+4 and DELAY_CYCLES+DISABLE_CYCLES+4 edges after the flag.
- A temperature change reaches both outputs after two edges.

The bench drives every input on a falling edge and counts rising edges from that point. It samples on the falling edge one cycle before and exactly on each due edge, so a result that arrives early or late by one cycle is caught.

// File: rtl/bg_pkg.sv
package bg_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DELAY = 2'd1,
    ST_OFF   = 2'd2,
    ST_RETRY = 2'd3
  } bg_state_t;
endpackage

// File: rtl/bg_sync.sv
module bg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/bg_bridge_fsm.sv
module bg_bridge_fsm
  import bg_pkg::*;
#(
  parameter int DELAY_CYCLES   = 8,
  parameter int DISABLE_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic trip,
  output logic run_en
);
  localparam int MAXC = (DELAY_CYCLES > DISABLE_CYCLES) ? DELAY_CYCLES : DISABLE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(DELAY_CYCLES - 1);
  localparam logic [CW-1:0] DIS_LAST = CW'(DISABLE_CYCLES - 1);

  bg_state_t     state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_RUN: begin
          cnt_q <= '0;
          if (trip) state_q <= ST_DELAY;
        end
        ST_DELAY: begin
          if (cnt_q == DLY_LAST) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_OFF: begin
          if (cnt_q == DIS_LAST) begin
            state_q <= ST_RETRY;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          cnt_q   <= '0;
          state_q <= trip ? ST_DELAY : ST_RUN;
        end
      endcase
    end
  end

  assign run_en = (state_q != ST_OFF);
endmodule

// File: rtl/bg_thermal.sv
module bg_thermal #(
  parameter int TW           = 8,
  parameter int TRIP_TEMP    = 165,
  parameter int RELEASE_TEMP = 150
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] temp_code,
  output logic          hot
);
  localparam logic [TW-1:0] TRIP_C = TW'(TRIP_TEMP);
  localparam logic [TW-1:0] REL_C  = TW'(RELEASE_TEMP);

  always_ff @(posedge clk) begin
    if (rst)                     hot <= 1'b0;
    else if (temp_code >= TRIP_C) hot <= 1'b1;
    else if (temp_code <= REL_C)  hot <= 1'b0;
  end
endmodule

// File: rtl/bridge_guard_top.sv
module bridge_guard_top #(
  parameter int NUM_BRIDGES    = 2,
  parameter int TW             = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int DELAY_CYCLES   = 8,
  parameter int DISABLE_CYCLES = 20,
  parameter int TRIP_TEMP      = 165,
  parameter int RELEASE_TEMP   = 150
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_BRIDGES-1:0] oc_raw,
  input  logic [TW-1:0]          temp_code,
  input  logic                   link_en,
  output logic [NUM_BRIDGES-1:0] fault,
  output logic [NUM_BRIDGES-1:0] bridge_en
);
  logic [NUM_BRIDGES-1:0] oc_s;
  logic [NUM_BRIDGES-1:0] trip;
  logic [NUM_BRIDGES-1:0] run_en;
  logic [NUM_BRIDGES-1:0] en_next;
  logic                   hot_q;

  bg_sync #(.W(NUM_BRIDGES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (oc_raw),
    .q   (oc_s)
  );

  bg_thermal #(.TW(TW), .TRIP_TEMP(TRIP_TEMP), .RELEASE_TEMP(RELEASE_TEMP)) u_therm (
    .clk       (clk),
    .rst       (rst),
    .temp_code (temp_code),
    .hot       (hot_q)
  );

  for (genvar i = 0; i < NUM_BRIDGES; i++) begin : g_bridge
    assign trip[i] = link_en ? (|oc_s) : oc_s[i];

    bg_bridge_fsm #(.DELAY_CYCLES(DELAY_CYCLES), .DISABLE_CYCLES(DISABLE_CYCLES)) u_fsm (
      .clk    (clk),
      .rst    (rst),
      .trip   (trip[i]),
      .run_en (run_en[i])
    );
  end

  always_comb begin
    if (hot_q)        en_next = '0;
    else if (link_en) en_next = {NUM_BRIDGES{&run_en}};
    else              en_next = run_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bridge_en <= '0;
      fault     <= '0;
    end else begin
      bridge_en <= en_next;
      fault     <= oc_s | {NUM_BRIDGES{hot_q}};
    end
  end
endmodule

// File: rtl/bg_checker.sv
module bg_checker #(
  parameter int NB           = 2,
  parameter int TW           = 8,
  parameter int TRIP_TEMP    = 165,
  parameter int RELEASE_TEMP = 150
) (
  input logic          clk,
  input logic          rst,
  input logic [TW-1:0] temp_code,
  input logic          link_en,
  input logic [NB-1:0] fault,
  input logic [NB-1:0] bridge_en,
  input logic          hot
);
  localparam logic [TW-1:0] TRIP_C = TW'(TRIP_TEMP);
  localparam logic [TW-1:0] REL_C  = TW'(RELEASE_TEMP);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (bridge_en == '0 && fault == '0)); // R1

  AST_TRIP_SETS_HOT: assert property (@(posedge clk) disable iff (rst)
    (temp_code >= TRIP_C) |=> hot); // R7

  AST_HOT_KILLS_EN: assert property (@(posedge clk) disable iff (rst)
    hot |=> (bridge_en == '0 && fault == '1)); // R7

  AST_HOT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (hot && temp_code > REL_C) |=> hot); // R8

  AST_COOL_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!hot && temp_code < TRIP_C) |=> !hot); // R8

  AST_LINK_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $past(link_en) |-> (bridge_en == '0 || bridge_en == '1)); // R9
endmodule

bind bridge_guard_top bg_checker #(
  .NB(NUM_BRIDGES), .TW(TW), .TRIP_TEMP(TRIP_TEMP), .RELEASE_TEMP(RELEASE_TEMP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .temp_code (temp_code),
  .link_en   (link_en),
  .fault     (fault),
  .bridge_en (bridge_en),
  .hot       (hot_q)
);

// File: tb/tb_bridge_guard_top.sv
module tb_bridge_guard_top;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;
  localparam int S = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] oc_raw = 2'b00;
  logic [7:0] temp_code = 8'd25;
  logic       link_en = 1'b0;
  logic [1:0] fault;
  logic [1:0] bridge_en;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_guard_top #(.DELAY_CYCLES(D), .DISABLE_CYCLES(S)) dut (
    .clk(clk), .rst(rst), .oc_raw(oc_raw), .temp_code(temp_code),
    .link_en(link_en), .fault(fault), .bridge_en(bridge_en)
  );

  // {temp code, expected shutdown}
  localparam logic [8:0] THERM_VEC [9] = '{
    {8'd100, 1'b0}, {8'd164, 1'b0}, {8'd165, 1'b1}, {8'd160, 1'b1}, {8'd151, 1'b1},
    {8'd150, 1'b0}, {8'd160, 1'b0}, {8'd200, 1'b1}, {8'd149, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    chk("R1 enables in reset", bridge_en, 2'b00);
    chk("R1 fault in reset", fault, 2'b00);
    step(2);
    rst = 1'b0;
    step(1);
    chk("R1 enables after reset", bridge_en, 2'b11);
    chk("R1 fault after reset", fault, 2'b00);

    // thermal hysteresis table
    for (int v = 0; v < 9; v++) begin
      temp_code = THERM_VEC[v][8:1];
      step(2);
      chk("R7 R8 thermal enables", bridge_en, THERM_VEC[v][0] ? 2'b00 : 2'b11);
      chk("R7 R8 thermal fault", fault, THERM_VEC[v][0] ? 2'b11 : 2'b00);
    end
    temp_code = 8'd40;
    step(3);

    // single trip on bridge 0, unlinked
    oc_raw = 2'b01;
    step(2);
    chk("R2 fault not yet", fault, 2'b00);
    step(1);
    chk("R2 R3 fault own bridge", fault, 2'b01);
    oc_raw = 2'b00;
    chk("R4 still enabled", bridge_en, 2'b11);
    step(D);
    chk("R4 enabled before delay end", bridge_en, 2'b11);
    chk("R3 fault cleared", fault, 2'b00);
    step(1);
    chk("R4 R3 bridge0 off only", bridge_en, 2'b10);
    step(S - 1);
    chk("R5 still off", bridge_en, 2'b10);
    step(1);
    chk("R5 back on", bridge_en, 2'b11);
    step(5);

    // persistent trip on bridge 1
    oc_raw = 2'b10;
    step(4 + D + S);
    chk("R6 retry cycle on", bridge_en, 2'b11);
    step(D);
    chk("R6 second delay running", bridge_en, 2'b11);
    step(1);
    chk("R6 off again", bridge_en, 2'b01);
    oc_raw = 2'b00;
    step(S + 10);
    chk("R6 recovered", bridge_en, 2'b11);

    // linked mode
    link_en = 1'b1;
    step(2);
    oc_raw = 2'b01;
    step(3);
    chk("R9 fault only bridge0", fault, 2'b01);
    oc_raw = 2'b00;
    step(D + 1);
    chk("R9 both off", bridge_en, 2'b00);
    step(S);
    chk("R9 both back", bridge_en, 2'b11);
    link_en = 1'b0;
    step(2);

    // shutdown during an off interval, then release
    oc_raw = 2'b01;
    step(3);
    oc_raw = 2'b00;
    step(D + 1);
    temp_code = 8'd170;
    step(2);
    chk("R7 shutdown overrides", bridge_en, 2'b00);
    temp_code = 8'd100;
    step(2);
    chk("R8 release keeps off bridge off", bridge_en, 2'b10);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule